// File: doc/BRIEF.md
# Set-Associative L1 Data Cache Tag and Control Unit

This block is the decision core of a small first-level data cache. Each cycle it may take one request: an address, a read/write flag, an atomic flag and an access class (global or local). In the same cycle it answers HIT, MISS or RESERVATION_FAIL. It updates the per-line state (INVALID, VALID, MODIFIED) and the per-set recency order. Any traffic it sends toward the next memory level goes into a fixed-depth outgoing queue. The block stores no data. It only decides what happens to tags, line states and outgoing requests.

The write behaviour depends on a policy input and on the access class. A global write that hits sends the write downstream and drops the line. A local write that hits under write-back only marks the line dirty. A write that misses is sent downstream and never allocates a line. A read miss allocates a way and registers the line in a small table of pending fills. Later read misses to the same line merge into that entry instead of issuing a second fill. A fill-response input closes the entry and makes the line valid.

Top module: `l1dc_top`

## Requirements
- R1: After reset, all lines are INVALID and the outgoing queue and the pending-fill table are empty. `respStatus` reads NONE (3) in any cycle without a request. The response codes are HIT=0, MISS=1, RESERVATION_FAIL=2.
- R2: When the policy is read-only (`wrPolicy`=0), a write request returns RESERVATION_FAIL and enqueues nothing.
- R3: Under write-back (`wrPolicy`=1), a local-class write hit returns HIT, enqueues nothing, refreshes recency and sets the line to MODIFIED. A MODIFIED line emits a write-back when it is later evicted.
- R4: A write hit under write-evict (`wrPolicy`=3), or a global-class write hit under any writable policy, needs one free queue slot. With a free slot it returns HIT, enqueues a WRITE entry (kind 1) for the line and sets the line to INVALID, so the next read of that line misses. With no free slot it returns RESERVATION_FAIL and the line stays valid.
- R5: Under write-through (`wrPolicy`=2), a local-class write hit needs one free slot. It returns HIT, enqueues a WRITE entry, refreshes recency and leaves the line valid.
- R6: A write miss needs one free slot. It then returns MISS and enqueues a WRITE entry without allocating a line. With no free slot it returns RESERVATION_FAIL.
- R7: A read hit returns HIT and makes the line most recently used. A non-pending INVALID way is chosen as victim first (lowest index). Otherwise the least recently used non-pending way is chosen.
- R8: An atomic global-class read hit also sets the line to MODIFIED.
- R9: A read miss returns RESERVATION_FAIL unless at least two queue slots are free.
- R10: A read miss to a line with no pending entry needs a free pending-fill entry and a non-pending victim way. It returns MISS and enqueues a full-line FILL read (kind 0). If the victim was MODIFIED, this is followed in the same cycle by a full-line WRITEBACK (kind 2) of the victim's line address.
- R11: A read miss to a line that already has a pending fill returns MISS and enqueues nothing while the entry holds fewer than MAX_MERGE requests. Otherwise it returns RESERVATION_FAIL. A read miss that needs a new entry when none is free returns RESERVATION_FAIL.
- R12: The outgoing queue is first-in first-out. Its head is shown on `mqValid`/`mqKind`/`mqLine`, and it pops one entry per cycle while `mqReady` is high.
- R13: A fill response for a pending line frees its entry and makes the line VALID, so the next read of it hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrPolicy | input | 2 | 0 read-only, 1 write-back, 2 write-through, 3 write-evict |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAtomic | input | 1 | Request is atomic |
| reqGlobal | input | 1 | 1 global class, 0 local class |
| respStatus | output | 2 | 0 HIT, 1 MISS, 2 RESERVATION_FAIL, 3 NONE |
| fillValid | input | 1 | Fill response present |
| fillLine | input | ADDR_W-log2(LINE_BYTES) | Line address of the fill |
| mqReady | input | 1 | Downstream accepts the queue head |
| mqValid | output | 1 | Queue head is valid |
| mqKind | output | 2 | 0 FILL read, 1 WRITE, 2 WRITEBACK |
| mqLine | output | ADDR_W-log2(LINE_BYTES) | Line address of the queue head |

## Verification
A wrong line state shows up only later, through a different answer: a dirty bit that was lost removes a WRITEBACK from a later eviction, and a line that failed to invalidate turns an expected MISS into a HIT. The directed sequences therefore follow each state change with the request that exposes it, usually within a few cycles. Recency faults show as the wrong victim line address in the queue, one cycle after the miss. Queue accounting faults show at once, as RESERVATION_FAIL appearing where a MISS was expected or the other way round.

// File: rtl/l1dc_pkg.sv
`timescale 1ns/1ps
package l1dc_pkg;
  typedef enum logic [1:0] {ST_HIT = 2'd0, ST_MISS = 2'd1, ST_FAIL = 2'd2, ST_NONE = 2'd3} resp_e;
  typedef enum logic [1:0] {POL_RO = 2'd0, POL_WB = 2'd1, POL_WT = 2'd2, POL_WE = 2'd3} pol_e;
  typedef enum logic [1:0] {LS_INVALID = 2'd0, LS_VALID = 2'd1, LS_MODIFIED = 2'd2} line_e;
  typedef enum logic [1:0] {MQ_FILL = 2'd0, MQ_WRITE = 2'd1, MQ_WRBACK = 2'd2} mqkind_e;

  // Lookup summary from datapath to control.
  typedef struct packed {
    logic    hit;
    logic    victimFound;
    logic    victimDirty;
    logic    mshrHit;
    logic    mshrCanMerge;
    logic    mshrFree;
    logic    slot1;
    logic    slot2;
  } look_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    touchHit;
    logic    markDirty;
    logic    markInvalid;
    logic    allocate;
    logic    mshrNew;
    logic    mshrMerge;
    logic    pushReq;
    mqkind_e pushReqKind;
    logic    pushVictim;
  } strobe_t;
endpackage

// File: rtl/l1dc_control.sv
`timescale 1ns/1ps
module l1dc_control
  import l1dc_pkg::*;
(
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    reqAtomic,
  input  logic    reqGlobal,
  input  pol_e    policy,
  input  look_t   look,
  output resp_e   status,
  output strobe_t stb
);
  always_comb begin
    stb    = '0;
    status = ST_NONE;
    if (reqValid) begin
      if (reqWrite) begin
        if (policy == POL_RO) begin
          status = ST_FAIL;
        end else if (look.hit) begin
          if (policy == POL_WB && !reqGlobal) begin
            status        = ST_HIT;
            stb.touchHit  = 1'b1;
            stb.markDirty = 1'b1;
          end else if (!look.slot1) begin
            status = ST_FAIL;
          end else if (policy == POL_WE || reqGlobal) begin
            status          = ST_HIT;
            stb.pushReq     = 1'b1;
            stb.pushReqKind = MQ_WRITE;
            stb.markInvalid = 1'b1;
          end else begin
            status          = ST_HIT;
            stb.pushReq     = 1'b1;
            stb.pushReqKind = MQ_WRITE;
            stb.touchHit    = 1'b1;
          end
        end else if (look.slot1) begin
          status          = ST_MISS;
          stb.pushReq     = 1'b1;
          stb.pushReqKind = MQ_WRITE;
        end else begin
          status = ST_FAIL;
        end
      end else begin
        if (look.hit) begin
          status        = ST_HIT;
          stb.touchHit  = 1'b1;
          stb.markDirty = reqAtomic && reqGlobal;
        end else if (!look.slot2) begin
          status = ST_FAIL;
        end else if (look.mshrHit) begin
          if (look.mshrCanMerge) begin
            status        = ST_MISS;
            stb.mshrMerge = 1'b1;
          end else begin
            status = ST_FAIL;
          end
        end else if (look.mshrFree && look.victimFound) begin
          status          = ST_MISS;
          stb.allocate    = 1'b1;
          stb.mshrNew     = 1'b1;
          stb.pushReq     = 1'b1;
          stb.pushReqKind = MQ_FILL;
          stb.pushVictim  = look.victimDirty;
        end else begin
          status = ST_FAIL;
        end
      end
    end
  end
endmodule

// File: rtl/l1dc_mshr.sv
`timescale 1ns/1ps
module l1dc_mshr #(
  parameter int LINE_W    = 12,
  parameter int WAY_W     = 1,
  parameter int MSHR_N    = 2,
  parameter int MAX_MERGE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lookLine,
  output logic              hit,
  output logic              canMerge,
  output logic              freeAvail,
  input  logic              doNew,
  input  logic [WAY_W-1:0]  newWay,
  input  logic              doMerge,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine,
  output logic              fillHit,
  output logic [WAY_W-1:0]  fillWay
);
  localparam int IDX_W = (MSHR_N > 1) ? $clog2(MSHR_N) : 1;
  localparam int MRG_W = $clog2(MAX_MERGE + 1);

  logic              vldQ  [MSHR_N];
  logic [LINE_W-1:0] lineQ [MSHR_N];
  logic [WAY_W-1:0]  wayQ  [MSHR_N];
  logic [MRG_W-1:0]  cntQ  [MSHR_N];

  logic [IDX_W-1:0] hitIdx, freeIdx, fillIdx;

  always_comb begin
    hit = 1'b0; hitIdx = '0;
    freeAvail = 1'b0; freeIdx = '0;
    fillHit = 1'b0; fillIdx = '0;
    for (int e = MSHR_N - 1; e >= 0; e--) begin
      if (vldQ[e] && lineQ[e] == lookLine) begin
        hit = 1'b1; hitIdx = IDX_W'(e);
      end
      if (!vldQ[e]) begin
        freeAvail = 1'b1; freeIdx = IDX_W'(e);
      end
      if (fillValid && vldQ[e] && lineQ[e] == fillLine) begin
        fillHit = 1'b1; fillIdx = IDX_W'(e);
      end
    end
    canMerge = hit && (cntQ[hitIdx] < MRG_W'(MAX_MERGE));
    fillWay  = wayQ[fillIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < MSHR_N; e++) begin
        vldQ[e]  <= 1'b0;
        lineQ[e] <= '0;
        wayQ[e]  <= '0;
        cntQ[e]  <= '0;
      end
    end else begin
      if (doNew) begin
        vldQ[freeIdx]  <= 1'b1;
        lineQ[freeIdx] <= lookLine;
        wayQ[freeIdx]  <= newWay;
        cntQ[freeIdx]  <= MRG_W'(1);
      end
      if (doMerge) cntQ[hitIdx] <= cntQ[hitIdx] + 1'b1;
      if (fillHit) vldQ[fillIdx] <= 1'b0;
    end
  end
endmodule

// File: rtl/l1dc_missq.sv
`timescale 1ns/1ps
module l1dc_missq
  import l1dc_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushA,
  input  mqkind_e           kindA,
  input  logic [LINE_W-1:0] lineA,
  input  logic              pushB,
  input  mqkind_e           kindB,
  input  logic [LINE_W-1:0] lineB,
  input  logic              popReady,
  output logic              headValid,
  output mqkind_e           headKind,
  output logic [LINE_W-1:0] headLine,
  output logic [CNT_W-1:0]  count
);
  mqkind_e           kindQ [DEPTH];
  logic [LINE_W-1:0] lineQ [DEPTH];
  logic [PTR_W-1:0]  rdQ, wrQ, bWr, wrNext;
  logic              pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headValid = (count != '0);
  assign headKind  = kindQ[rdQ];
  assign headLine  = lineQ[rdQ];
  assign pop       = popReady && headValid;
  assign bWr       = pushA ? nxt(wrQ) : wrQ;
  assign wrNext    = pushB ? nxt(bWr) : bWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ   <= '0;
      wrQ   <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kindQ[i] <= MQ_FILL;
        lineQ[i] <= '0;
      end
    end else begin
      if (pushA) begin
        kindQ[wrQ] <= kindA;
        lineQ[wrQ] <= lineA;
      end
      if (pushB) begin
        kindQ[bWr] <= kindB;
        lineQ[bWr] <= lineB;
      end
      wrQ   <= wrNext;
      if (pop) rdQ <= nxt(rdQ);
      count <= count + CNT_W'(pushA) + CNT_W'(pushB) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/l1dc_datapath.sv
`timescale 1ns/1ps
module l1dc_datapath
  import l1dc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int MQ_DEPTH   = 4,
  parameter int MSHR_N     = 2,
  parameter int MAX_MERGE  = 2,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CNT_W  = $clog2(MQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  strobe_t           stb,
  output look_t             look,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              mqReady,
  output logic              mqValid,
  output mqkind_e           mqKind,
  output logic [LINE_W-1:0] mqLine,
  output logic [CNT_W-1:0]  mqCount
);
  logic [IDX_W-1:0]  reqSet;
  logic [TAG_W-1:0]  reqTag;
  logic [LINE_W-1:0] reqLine;
  logic              unusedOffset;

  assign reqSet       = reqAddr[OFF_W +: IDX_W];
  assign reqTag       = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqLine      = reqAddr[ADDR_W-1:OFF_W];
  assign unusedOffset = ^reqAddr[OFF_W-1:0];

  logic [TAG_W-1:0] tagQ  [SETS][WAYS];
  line_e            stQ   [SETS][WAYS];
  logic             pendQ [SETS][WAYS];
  logic [WAY_W-1:0] rankQ [SETS][WAYS];

  logic             hitAny, invFound, oldFound;
  logic [WAY_W-1:0] hitWay, invWay, oldWay, vicWay, touchWay;
  logic             doTouch;
  logic [LINE_W-1:0] vicLine;

  always_comb begin
    hitAny = 1'b0; hitWay = '0;
    invFound = 1'b0; invWay = '0;
    oldFound = 1'b0; oldWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (stQ[reqSet][w] != LS_INVALID && tagQ[reqSet][w] == reqTag) begin
        hitAny = 1'b1; hitWay = WAY_W'(w);
      end
      if (!pendQ[reqSet][w] && (!oldFound || rankQ[reqSet][w] > rankQ[reqSet][oldWay])) begin
        oldFound = 1'b1; oldWay = WAY_W'(w);
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (stQ[reqSet][w] == LS_INVALID && !pendQ[reqSet][w]) begin
        invFound = 1'b1; invWay = WAY_W'(w);
      end
    end
    vicWay = invFound ? invWay : oldWay;
  end

  assign vicLine  = {tagQ[reqSet][vicWay], reqSet};
  assign doTouch  = stb.touchHit || stb.allocate;
  assign touchWay = stb.allocate ? vicWay : hitWay;

  logic             mshrHit, mshrCanMerge, mshrFree, fillHit;
  logic [WAY_W-1:0] fillWay;
  logic [IDX_W-1:0] fillSet;
  assign fillSet = fillLine[IDX_W-1:0];

  l1dc_mshr #(
    .LINE_W(LINE_W), .WAY_W(WAY_W), .MSHR_N(MSHR_N), .MAX_MERGE(MAX_MERGE)
  ) i_mshr (
    .clk(clk), .rstN(rstN),
    .lookLine(reqLine), .hit(mshrHit), .canMerge(mshrCanMerge), .freeAvail(mshrFree),
    .doNew(stb.mshrNew), .newWay(vicWay), .doMerge(stb.mshrMerge),
    .fillValid(fillValid), .fillLine(fillLine), .fillHit(fillHit), .fillWay(fillWay)
  );

  l1dc_missq #(
    .LINE_W(LINE_W), .DEPTH(MQ_DEPTH)
  ) i_missq (
    .clk(clk), .rstN(rstN),
    .pushA(stb.pushReq), .kindA(stb.pushReqKind), .lineA(reqLine),
    .pushB(stb.pushVictim), .kindB(MQ_WRBACK), .lineB(vicLine),
    .popReady(mqReady), .headValid(mqValid), .headKind(mqKind), .headLine(mqLine),
    .count(mqCount)
  );

  always_comb begin
    look              = '0;
    look.hit          = hitAny;
    look.victimFound  = invFound || oldFound;
    look.victimDirty  = (stQ[reqSet][vicWay] == LS_MODIFIED);
    look.mshrHit      = mshrHit;
    look.mshrCanMerge = mshrCanMerge;
    look.mshrFree     = mshrFree;
    look.slot1        = (int'(mqCount) + 1 <= MQ_DEPTH);
    look.slot2        = (int'(mqCount) + 2 <= MQ_DEPTH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagQ[s][w]  <= '0;
          stQ[s][w]   <= LS_INVALID;
          pendQ[s][w] <= 1'b0;
          rankQ[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      if (fillHit) begin
        stQ[fillSet][fillWay]   <= LS_VALID;
        pendQ[fillSet][fillWay] <= 1'b0;
      end
      if (doTouch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (rankQ[reqSet][w] < rankQ[reqSet][touchWay])
            rankQ[reqSet][w] <= rankQ[reqSet][w] + 1'b1;
        end
        rankQ[reqSet][touchWay] <= '0;
      end
      if (stb.markDirty)   stQ[reqSet][hitWay] <= LS_MODIFIED;
      if (stb.markInvalid) stQ[reqSet][hitWay] <= LS_INVALID;
      if (stb.allocate) begin
        tagQ[reqSet][vicWay]  <= reqTag;
        stQ[reqSet][vicWay]   <= LS_INVALID;
        pendQ[reqSet][vicWay] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/l1dc_top.sv
`timescale 1ns/1ps
module l1dc_top
  import l1dc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int MQ_DEPTH   = 4,
  parameter int MSHR_N     = 2,
  parameter int MAX_MERGE  = 2,
  localparam int LINE_W = ADDR_W - $clog2(LINE_BYTES),
  localparam int CNT_W  = $clog2(MQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        wrPolicy,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqAtomic,
  input  logic              reqGlobal,
  output logic [1:0]        respStatus,
  input  logic              fillValid,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              mqReady,
  output logic              mqValid,
  output logic [1:0]        mqKind,
  output logic [LINE_W-1:0] mqLine
);
  look_t            look;
  strobe_t          stb;
  resp_e            status;
  mqkind_e          headKind;
  logic [CNT_W-1:0] mqCount;

  l1dc_control i_control (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAtomic(reqAtomic), .reqGlobal(reqGlobal),
    .policy(pol_e'(wrPolicy)), .look(look), .status(status), .stb(stb)
  );

  l1dc_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SETS(SETS), .WAYS(WAYS),
    .MQ_DEPTH(MQ_DEPTH), .MSHR_N(MSHR_N), .MAX_MERGE(MAX_MERGE)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .stb(stb), .look(look),
    .fillValid(fillValid), .fillLine(fillLine), .mqReady(mqReady),
    .mqValid(mqValid), .mqKind(headKind), .mqLine(mqLine), .mqCount(mqCount)
  );

  assign respStatus = status;
  assign mqKind     = headKind;
endmodule

// File: rtl/l1dc_checker.sv
`timescale 1ns/1ps
module l1dc_checker #(
  parameter int MQ_DEPTH = 4,
  localparam int CNT_W = $clog2(MQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqWrite,
  input logic             reqGlobal,
  input logic [1:0]       wrPolicy,
  input logic [1:0]       respStatus,
  input logic             mqValid,
  input logic             mqReady,
  input logic [CNT_W-1:0] mqCount
);
  a_r1_idle_none: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> respStatus == 2'd3);

  a_r2_readonly_write_fails: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && wrPolicy == 2'd0) |-> respStatus == 2'd2);

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    int'(mqCount) <= MQ_DEPTH);

  a_r12_two_push_bound: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> int'(mqCount) <= int'($past(mqCount)) + 2);

  a_r9_fail_pushes_nothing: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && respStatus == 2'd2 && !(mqValid && mqReady)) |=> $stable(mqCount));

  a_r3_local_wb_hit_silent: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqGlobal && wrPolicy == 2'd1 && respStatus == 2'd0
     && !(mqValid && mqReady)) |=> $stable(mqCount));
endmodule

bind l1dc_top l1dc_checker #(.MQ_DEPTH(MQ_DEPTH)) i_l1dcChecker (.*);

// File: tb/test_l1dc_top.sv
`timescale 1ns/1ps
module test_l1dc_top;
  localparam int ADDR_W = 16;
  localparam int LINE_W = 12;
  localparam logic [1:0] RO = 2'd0, WB = 2'd1, WT = 2'd2, WE = 2'd3;
  localparam int HIT = 0, MISS = 1, FAIL = 2, NONE = 3;
  localparam int K_FILL = 0, K_WR = 1, K_WB = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] wrPolicy = WB;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqAtomic = 1'b0, reqGlobal = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0] respStatus;
  logic fillValid = 1'b0;
  logic [LINE_W-1:0] fillLine = '0;
  logic mqReady = 1'b0;
  logic mqValid;
  logic [1:0] mqKind;
  logic [LINE_W-1:0] mqLine;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  l1dc_top i_l1dc_top (
    .clk(clk), .rstN(rstN), .wrPolicy(wrPolicy), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqAtomic(reqAtomic), .reqGlobal(reqGlobal), .respStatus(respStatus),
    .fillValid(fillValid), .fillLine(fillLine), .mqReady(mqReady),
    .mqValid(mqValid), .mqKind(mqKind), .mqLine(mqLine)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic doReq(input int line, input bit wr, input bit at, input bit gl,
                       input logic [1:0] pol, input int exp, input string rq);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAtomic = at; reqGlobal = gl; wrPolicy = pol;
    reqAddr = ADDR_W'((line << 4) | 5);
    #1 chk(rq, "respStatus", int'(respStatus), exp);
    @(posedge clk);
    #1 reqValid = 1'b0; reqWrite = 1'b0; reqAtomic = 1'b0; reqGlobal = 1'b0;
  endtask

  task automatic expPop(input int kind, input int line, input string rq);
    @(negedge clk);
    #1;
    chk(rq, "mqValid", int'(mqValid), 1);
    chk(rq, "mqKind", int'(mqKind), kind);
    chk(rq, "mqLine", int'(mqLine), line);
    mqReady = 1'b1;
    @(posedge clk);
    #1 mqReady = 1'b0;
  endtask

  task automatic expEmpty(input string rq);
    @(negedge clk);
    #1 chk(rq, "mqValid(empty)", int'(mqValid), 0);
  endtask

  task automatic doFill(input int line);
    @(negedge clk);
    fillValid = 1'b1; fillLine = LINE_W'(line);
    @(posedge clk);
    #1 fillValid = 1'b0;
  endtask

  task automatic tReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1", "respStatus idle", int'(respStatus), NONE);
    chk("R1", "mqValid after reset", int'(mqValid), 0);
    doReq(12'h001, 0, 0, 0, WB, MISS, "R1");   // every line starts INVALID
    expPop(K_FILL, 12'h001, "R1");
  endtask

  task automatic tReadOnly();
    doReq(12'h030, 1, 0, 0, RO, FAIL, "R2");
    expEmpty("R2");
    doReq(12'h030, 1, 0, 1, RO, FAIL, "R2");
    expEmpty("R2");
  endtask

  task automatic tFillAndLru();
    doFill(12'h001);
    doReq(12'h001, 0, 0, 0, WB, HIT, "R13");
    doReq(12'h001, 1, 0, 0, WB, HIT, "R3");    // local write-back hit: dirty
    expEmpty("R3");
    doReq(12'h005, 0, 0, 0, WB, MISS, "R10");
    expPop(K_FILL, 12'h005, "R10");
    doFill(12'h005);
    doReq(12'h001, 0, 0, 0, WB, HIT, "R7");    // 0x005 becomes LRU
    doReq(12'h009, 0, 0, 0, WB, MISS, "R7");
    expPop(K_FILL, 12'h009, "R7");
    expEmpty("R7");                            // clean victim 0x005, no writeback
    doFill(12'h009);
    doReq(12'h005, 0, 0, 0, WB, MISS, "R7");   // evicts dirty 0x001
    expPop(K_FILL, 12'h005, "R10");
    expPop(K_WB, 12'h001, "R3");
    doFill(12'h005);
  endtask

  task automatic tWriteHits();
    doReq(12'h002, 0, 0, 0, WB, MISS, "R10");
    expPop(K_FILL, 12'h002, "R10");
    doFill(12'h002);
    doReq(12'h002, 1, 0, 1, WB, HIT, "R4");    // global write hit evicts
    expPop(K_WR, 12'h002, "R4");
    doReq(12'h002, 0, 0, 0, WB, MISS, "R4");
    expPop(K_FILL, 12'h002, "R4");
    doFill(12'h002);
    doReq(12'h002, 1, 0, 0, WE, HIT, "R4");    // write-evict policy, local
    expPop(K_WR, 12'h002, "R4");
    doReq(12'h002, 0, 0, 0, WB, MISS, "R4");
    expPop(K_FILL, 12'h002, "R4");
    doFill(12'h002);
    doReq(12'h002, 1, 0, 0, WT, HIT, "R5");
    expPop(K_WR, 12'h002, "R5");
    doReq(12'h002, 0, 0, 0, WB, HIT, "R5");
  endtask

  task automatic tWriteMiss();
    doReq(12'h00A, 1, 0, 0, WB, MISS, "R6");
    expPop(K_WR, 12'h00A, "R6");
    doReq(12'h00A, 0, 0, 0, WB, MISS, "R6");   // not allocated by the write
    expPop(K_FILL, 12'h00A, "R6");
    doFill(12'h00A);
  endtask

  task automatic tAtomic();
    doReq(12'h003, 0, 0, 0, WB, MISS, "R8");
    expPop(K_FILL, 12'h003, "R8");
    doFill(12'h003);
    doReq(12'h003, 0, 1, 1, WB, HIT, "R8");
    expEmpty("R8");
    doReq(12'h007, 0, 0, 0, WB, MISS, "R8");
    expPop(K_FILL, 12'h007, "R8");
    doFill(12'h007);
    doReq(12'h007, 0, 0, 0, WB, HIT, "R7");
    doReq(12'h00B, 0, 0, 0, WB, MISS, "R8");
    expPop(K_FILL, 12'h00B, "R8");
    expPop(K_WB, 12'h003, "R8");
    doFill(12'h00B);
  endtask

  task automatic tMerge();
    doReq(12'h010, 0, 0, 0, WB, MISS, "R11");
    doReq(12'h010, 0, 0, 0, WB, MISS, "R11");  // merged
    doReq(12'h010, 0, 0, 0, WB, FAIL, "R11");  // merge limit reached
    expPop(K_FILL, 12'h010, "R11");
    expEmpty("R11");
    doFill(12'h010);
    doReq(12'h010, 0, 0, 0, WB, HIT, "R13");
    doReq(12'h014, 0, 0, 0, WB, MISS, "R11");
    doReq(12'h018, 0, 0, 0, WB, MISS, "R11");
    doReq(12'h00D, 0, 0, 0, WB, FAIL, "R11");  // no free pending entry
    expPop(K_FILL, 12'h014, "R12");
    expPop(K_FILL, 12'h018, "R12");
    doFill(12'h014);
    doFill(12'h018);
  endtask

  task automatic tQueueLimits();
    doReq(12'h020, 1, 0, 0, WB, MISS, "R6");
    doReq(12'h021, 1, 0, 0, WB, MISS, "R6");
    doReq(12'h022, 1, 0, 0, WB, MISS, "R6");
    doReq(12'h023, 0, 0, 0, WB, FAIL, "R9");   // one slot left
    doReq(12'h024, 1, 0, 0, WB, MISS, "R6");
    doReq(12'h025, 1, 0, 0, WB, FAIL, "R6");   // queue full
    doReq(12'h005, 1, 0, 1, WB, FAIL, "R4");   // global hit, no slot
    expPop(K_WR, 12'h020, "R12");
    expPop(K_WR, 12'h021, "R12");
    expPop(K_WR, 12'h022, "R12");
    expPop(K_WR, 12'h024, "R12");
    expEmpty("R12");
    doReq(12'h005, 0, 0, 0, WB, HIT, "R4");    // still valid after failed evict
  endtask

  initial begin
    tReset();
    tReadOnly();
    tFillAndLru();
    tWriteHits();
    tWriteMiss();
    tAtomic();
    tMerge();
    tQueueLimits();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule